// File: doc/BRIEF.md
# Multi-block DMA channel sequencer

This block runs a single DMA channel through a chain of blocks described by linked descriptors held in memory. Software programs a source base address, the address of the first descriptor and two interrupt mask bits, then sets the channel's enable bit. For every block the channel fetches a four-word descriptor over a request/valid read port. The descriptor gives the destination address, a control word, the address of the next descriptor and the block length in transfer units. The source address is then reloaded from the programmed base. A word-by-word mover copies the block through a single read/write memory port, stepping each address according to the width and address-mode fields of the control word.

At the end of each block the channel may raise a block-complete status. When it does, the channel holds before fetching the next descriptor until software clears that status. After the block whose next pointer is zero, the channel raises transfer-complete and drops its own enable bit. Software can read the enable bit to find out whether the channel is free. Writing zero to the enable bit aborts the channel.

Top module: `dma_block_sequencer`

## Requirements
- R1: After reset the enable, source base, first-descriptor, mask and status registers read zero, and `irq`, `desc_req` and `mem_req` are low.
- R2: Register 0 bit 0 reads back the channel enable. Writing 1 while the channel is idle starts a descriptor fetch at the address held in register 2. Writing 1 while the channel is running has no effect.
- R3: A descriptor is read as four single-word requests at pointer +0, +4, +8 and +12, with one request outstanding at a time. The four words are the destination address, the control word, the next pointer and the block size. No memory access is made while a descriptor is being fetched.
- R4: Each transfer unit is a read at the current source address followed by a write of the returned data to the current destination address. `mem_size` carries the source width (control bits 1:0) on reads and the destination width (bits 3:2) on writes. The width codes are 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes. After each unit, each address moves by its width in bytes according to its mode field (source bits 5:4, destination bits 7:6): 0 increments, 1 decrements, and 2 or 3 holds the address.
- R5: The first read of every block is at the source base address in register 1. The destination of every block comes from its descriptor.
- R6: At the end of a block, status bit 0 is set only if control bit 13 is 1 and mask bit 0 (register 3) is 1. When it is set and a next descriptor follows, the channel issues no descriptor or memory request until software clears bit 0 by writing a 1 to it in register 4.
- R7: After the block whose next pointer is zero, status bit 1 is set and the enable bit reads 0.
- R8: Status bits are sticky and are cleared by writing 1 to register 4. `irq` equals status bit 0 OR (status bit 1 AND mask bit 1), delayed by one register stage.
- R9: Writing 0 to the enable bit while the channel runs returns it to idle on the next cycle. After that, no further descriptor or memory requests are issued.
- R10: A block of size zero makes no memory access and goes straight to block-end processing.
- R11: `mem_master` equals control bit 8 on reads and control bit 9 on writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| desc_req | output | 1 | One-cycle descriptor word request |
| desc_addr | output | 32 | Descriptor word address |
| desc_valid | input | 1 | Descriptor word returned |
| desc_rdata | input | 32 | Descriptor word data |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | DATA_W | Write data |
| mem_size | output | 2 | Access width code |
| mem_master | output | 1 | Master layer select for the access |
| mem_ack | input | 1 | Access accepted; read data valid |
| mem_rdata | input | DATA_W | Read data |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is the hold between blocks, where the channel sits with a completed block and a valid next pointer and must stay silent. The stimulus builds a two-descriptor chain with interrupt enable and block mask set. It polls the status register until bit 0 rises, then watches both request ports for many idle cycles before clearing the bit and confirming that the second block runs. The address arithmetic is covered by a sweep over every combination of source width, destination width and both address modes, with a memory that acknowledges on an irregular pattern.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  localparam int ADDR_W = 32;

  localparam logic [2:0] RA_ENABLE = 3'd0;
  localparam logic [2:0] RA_SRC    = 3'd1;
  localparam logic [2:0] RA_FIRST  = 3'd2;
  localparam logic [2:0] RA_MASK   = 3'd3;
  localparam logic [2:0] RA_STATUS = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_LOAD, ST_XFER, ST_BDONE, ST_STALL
  } seq_state_t;

  typedef enum logic [1:0] {MV_IDLE, MV_RD, MV_WR} mv_state_t;

  typedef struct packed {
    logic [17:0] rsvd;
    logic        int_en;
    logic [2:0]  flow;
    logic        dst_master;
    logic        src_master;
    logic [1:0]  dst_mode;
    logic [1:0]  src_mode;
    logic [1:0]  dst_width;
    logic [1:0]  src_width;
  } ctrl_t;

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                  input logic [1:0] width,
                                                  input logic [1:0] mode);
    logic [ADDR_W-1:0] bytes;
    bytes = (width == 2'd0) ? ADDR_W'(1) : (width == 2'd1) ? ADDR_W'(2) : ADDR_W'(4);
    case (mode)
      2'd0:    return a + bytes;
      2'd1:    return a - bytes;
      default: return a;
    endcase
  endfunction

endpackage

// File: rtl/dma_seq_regs.sv
module dma_seq_regs
  import dma_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              set_blk,
  input  logic              set_xfer,
  output logic              chan_en,
  output logic              start,
  output logic              abort,
  output logic [ADDR_W-1:0] src_base,
  output logic [ADDR_W-1:0] first_desc,
  output logic              mask_blk,
  output logic              mask_xfer,
  output logic              blk_st,
  output logic              xfer_st,
  output logic              irq
);

  logic en_wr, st_wr;

  assign en_wr = reg_we && (reg_addr == RA_ENABLE);
  assign st_wr = reg_we && (reg_addr == RA_STATUS);
  assign start = en_wr && reg_wdata[0] && !chan_en;
  assign abort = en_wr && !reg_wdata[0] && chan_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_en    <= 1'b0;
      src_base   <= '0;
      first_desc <= '0;
      mask_blk   <= 1'b0;
      mask_xfer  <= 1'b0;
      blk_st     <= 1'b0;
      xfer_st    <= 1'b0;
      irq        <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      if (set_xfer)   chan_en <= 1'b0;
      else if (en_wr) chan_en <= reg_wdata[0];
      if (reg_we && reg_addr == RA_SRC)   src_base   <= reg_wdata[ADDR_W-1:0];
      if (reg_we && reg_addr == RA_FIRST) first_desc <= reg_wdata[ADDR_W-1:0];
      if (reg_we && reg_addr == RA_MASK) begin
        mask_blk  <= reg_wdata[0];
        mask_xfer <= reg_wdata[1];
      end
      blk_st  <= (blk_st  && !(st_wr && reg_wdata[0])) || set_blk;
      xfer_st <= (xfer_st && !(st_wr && reg_wdata[1])) || set_xfer;
      irq     <= blk_st || (xfer_st && mask_xfer);
      case (reg_addr)
        RA_ENABLE: reg_rdata <= {31'd0, chan_en};
        RA_SRC:    reg_rdata <= 32'(src_base);
        RA_FIRST:  reg_rdata <= 32'(first_desc);
        RA_MASK:   reg_rdata <= {30'd0, mask_xfer, mask_blk};
        RA_STATUS: reg_rdata <= {30'd0, xfer_st, blk_st};
        default:   reg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/dma_seq_mover.sv
module dma_seq_mover
  import dma_seq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              kill,
  input  logic [ADDR_W-1:0] src0,
  input  logic [ADDR_W-1:0] dst0,
  input  logic [CNT_W-1:0]  units,
  input  ctrl_t             ctrl,
  output logic              done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [1:0]        mem_size,
  output logic              mem_master,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);

  mv_state_t         mv;
  ctrl_t             cfg;
  logic [ADDR_W-1:0] src_a, dst_a, nxt_src, nxt_dst;
  logic [CNT_W-1:0]  remain;
  logic              unused_cfg;

  assign unused_cfg = ^{cfg.rsvd, cfg.int_en, cfg.flow};

  always_comb begin
    nxt_src = step_addr(src_a, cfg.src_width, cfg.src_mode);
    nxt_dst = step_addr(dst_a, cfg.dst_width, cfg.dst_mode);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mv <= MV_IDLE; cfg <= '0; src_a <= '0; dst_a <= '0; remain <= '0;
      done <= 1'b0; mem_req <= 1'b0; mem_we <= 1'b0; mem_addr <= '0;
      mem_wdata <= '0; mem_size <= '0; mem_master <= 1'b0;
    end else if (kill) begin
      mv <= MV_IDLE; done <= 1'b0; mem_req <= 1'b0; mem_we <= 1'b0;
    end else begin
      done <= 1'b0;
      case (mv)
        MV_IDLE: if (start) begin
          cfg        <= ctrl;
          src_a      <= src0;
          dst_a      <= dst0;
          remain     <= units;
          mem_req    <= 1'b1;
          mem_we     <= 1'b0;
          mem_addr   <= src0;
          mem_size   <= ctrl.src_width;
          mem_master <= ctrl.src_master;
          mv         <= MV_RD;
        end
        MV_RD: if (mem_ack) begin
          mem_wdata  <= mem_rdata;
          mem_we     <= 1'b1;
          mem_addr   <= dst_a;
          mem_size   <= cfg.dst_width;
          mem_master <= cfg.dst_master;
          mv         <= MV_WR;
        end
        MV_WR: if (mem_ack) begin
          src_a <= nxt_src;
          dst_a <= nxt_dst;
          if (remain == CNT_W'(1)) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            done    <= 1'b1;
            mv      <= MV_IDLE;
          end else begin
            remain     <= remain - CNT_W'(1);
            mem_we     <= 1'b0;
            mem_addr   <= nxt_src;
            mem_size   <= cfg.src_width;
            mem_master <= cfg.src_master;
            mv         <= MV_RD;
          end
        end
        default: mv <= MV_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_block_sequencer.sv
module dma_block_sequencer
  import dma_seq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              desc_req,
  output logic [31:0]       desc_addr,
  input  logic              desc_valid,
  input  logic [31:0]       desc_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [1:0]        mem_size,
  output logic              mem_master,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              irq
);

  seq_state_t        state;
  logic [1:0]        widx;
  logic              waiting, mv_start, mv_done;
  logic [ADDR_W-1:0] cur_ptr, dst_w, next_w;
  ctrl_t             ctrl_w;
  logic [31:0]       size_w;
  logic [CNT_W-1:0]  units;
  logic              chan_en, start, abort, blk_raise, set_blk, set_xfer;
  logic [ADDR_W-1:0] src_base, first_desc;
  logic              mask_blk, mask_xfer, blk_st, xfer_st;
  logic              unused_bits;

  assign units       = size_w[CNT_W-1:0];
  assign blk_raise   = ctrl_w.int_en && mask_blk;
  assign set_blk     = (state == ST_BDONE) && blk_raise;
  assign set_xfer    = (state == ST_BDONE) && (next_w == '0);
  assign unused_bits = ^{ctrl_w.flow, ctrl_w.rsvd, size_w};

  dma_seq_regs regs_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .set_blk(set_blk),
    .set_xfer(set_xfer), .chan_en(chan_en), .start(start), .abort(abort),
    .src_base(src_base), .first_desc(first_desc), .mask_blk(mask_blk),
    .mask_xfer(mask_xfer), .blk_st(blk_st), .xfer_st(xfer_st), .irq(irq)
  );

  dma_seq_mover #(.CNT_W(CNT_W), .DATA_W(DATA_W)) mover_i (
    .clk(clk), .rst(rst), .start(mv_start), .kill(abort), .src0(src_base),
    .dst0(dst_w), .units(units), .ctrl(ctrl_w), .done(mv_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_size(mem_size), .mem_master(mem_master),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; widx <= '0; waiting <= 1'b0; desc_req <= 1'b0;
      desc_addr <= '0; cur_ptr <= '0; dst_w <= '0; ctrl_w <= '0;
      next_w <= '0; size_w <= '0; mv_start <= 1'b0;
    end else if (abort) begin
      state <= ST_IDLE; waiting <= 1'b0; desc_req <= 1'b0; mv_start <= 1'b0;
    end else begin
      mv_start <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          cur_ptr <= first_desc;
          widx    <= '0;
          waiting <= 1'b0;
          state   <= ST_FETCH;
        end
        ST_FETCH: begin
          if (!waiting) begin
            desc_req  <= 1'b1;
            desc_addr <= cur_ptr + {28'd0, widx, 2'b00};
            waiting   <= 1'b1;
          end else begin
            desc_req <= 1'b0;
            if (desc_valid) begin
              case (widx)
                2'd0:    dst_w  <= desc_rdata;
                2'd1:    ctrl_w <= ctrl_t'(desc_rdata);
                2'd2:    next_w <= desc_rdata;
                default: size_w <= desc_rdata;
              endcase
              waiting <= 1'b0;
              widx    <= widx + 2'd1;
              if (widx == 2'd3) state <= ST_LOAD;
            end
          end
        end
        ST_LOAD: begin
          if (units == '0) state <= ST_BDONE;
          else begin
            mv_start <= 1'b1;
            state    <= ST_XFER;
          end
        end
        ST_XFER: if (mv_done) state <= ST_BDONE;
        ST_BDONE: begin
          if (next_w == '0) state <= ST_IDLE;
          else begin
            cur_ptr <= next_w;
            widx    <= '0;
            state   <= blk_raise ? ST_STALL : ST_FETCH;
          end
        end
        ST_STALL: if (!blk_st) state <= ST_FETCH;
        default:  state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk
  import dma_seq_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input seq_state_t  state,
  input logic        desc_req,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] src_base,
  input logic        chan_en,
  input logic        blk_st,
  input logic        xfer_st,
  input logic        blk_raise,
  input logic        reg_we,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata
);

  assert_stall_silent_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STALL) |-> (!desc_req && !mem_req));

  assert_blk_gate_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(blk_st) |-> $past(blk_raise && (state == ST_BDONE)));

  assert_done_drops_en_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(xfer_st) |-> !chan_en);

  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 3'd0 && !reg_wdata[0] && chan_en)
      |=> (state == ST_IDLE && !mem_req && !desc_req));

  assert_src_reload_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_req) && !mem_we) |-> (mem_addr == src_base));

  assert_fetch_no_mem_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |-> !mem_req);

endmodule

bind dma_block_sequencer dma_seq_chk chk_i (
  .clk(clk), .rst(rst), .state(state), .desc_req(desc_req),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .src_base(src_base), .chan_en(chan_en), .blk_st(blk_st),
  .xfer_st(xfer_st), .blk_raise(blk_raise), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/dma_block_sequencer_tb.sv
module dma_block_sequencer_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        desc_req;
  logic [31:0] desc_addr;
  logic        desc_valid = 1'b0;
  logic [31:0] desc_rdata = '0;
  logic        mem_req, mem_we, mem_master;
  logic [31:0] mem_addr, mem_wdata;
  logic [1:0]  mem_size;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        irq;

  always #2 clk = ~clk;

  dma_block_sequencer dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .desc_req(desc_req),
    .desc_addr(desc_addr), .desc_valid(desc_valid), .desc_rdata(desc_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_size(mem_size), .mem_master(mem_master),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] dmem [int];
  logic [31:0] rd_a [0:511];
  logic [1:0]  rd_s [0:511];
  logic        rd_m [0:511];
  logic [31:0] wr_a [0:511];
  logic [31:0] wr_d [0:511];
  logic [1:0]  wr_s [0:511];
  logic        wr_m [0:511];
  logic [31:0] da_log [0:63];
  int rd_n = 0, wr_n = 0, dr_n = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic        pend = 1'b0;
  logic [31:0] paddr = '0;

  function automatic logic [31:0] rdfun(input logic [31:0] a);
    return (a * 32'h0001_9E37) ^ 32'hC3A5_0000;
  endfunction

  function automatic logic [31:0] nstep(input logic [31:0] a, input logic [1:0] w,
                                        input logic [1:0] m);
    int b;
    b = (w == 0) ? 1 : (w == 1) ? 2 : 4;
    if (m == 0) return a + b;
    if (m == 1) return a - b;
    return a;
  endfunction

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ack = 1'b0;
    if (mem_req && (lfsr[0] || lfsr[3])) begin
      mem_ack = 1'b1;
      if (mem_we) begin
        if (wr_n < 512) begin
          wr_a[wr_n] = mem_addr; wr_d[wr_n] = mem_wdata;
          wr_s[wr_n] = mem_size; wr_m[wr_n] = mem_master;
        end
        wr_n++;
      end else begin
        mem_rdata = rdfun(mem_addr);
        if (rd_n < 512) begin
          rd_a[rd_n] = mem_addr; rd_s[rd_n] = mem_size; rd_m[rd_n] = mem_master;
        end
        rd_n++;
      end
    end
  end

  always @(negedge clk) begin
    desc_valid = 1'b0;
    if (pend) begin
      desc_valid = 1'b1;
      desc_rdata = dmem.exists(int'(paddr)) ? dmem[int'(paddr)] : 32'd0;
      pend = 1'b0;
    end
    if (desc_req) begin
      pend = 1'b1;
      paddr = desc_addr;
      if (dr_n < 64) da_log[dr_n] = desc_addr;
      dr_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    tick();
    d = reg_rdata;
  endtask

  task automatic put_desc(input int base, input logic [31:0] dst, c, nxt, sz);
    dmem[base] = dst; dmem[base + 4] = c; dmem[base + 8] = nxt; dmem[base + 12] = sz;
  endtask

  task automatic clear_logs();
    rd_n = 0; wr_n = 0; dr_n = 0;
  endtask

  task automatic wait_idle(output bit ok);
    ok = 1'b0;
    reg_addr = 3'd0;
    tick(3);
    for (int i = 0; i < 4000; i++) begin
      tick();
      if (!reg_rdata[0]) begin ok = 1'b1; break; end
    end
  endtask

  task automatic verify_block(inout int idx, input logic [31:0] s0, d0, c,
                              input int n, input string tag);
    logic [31:0] s, d;
    s = s0; d = d0;
    for (int k = 0; k < n; k++) begin
      chk(rd_a[idx] == s, {tag, " R5 R4 read address"}, rd_a[idx], s);
      chk(wr_a[idx] == d, {tag, " R4 write address"}, wr_a[idx], d);
      chk(wr_d[idx] == rdfun(s), {tag, " R4 write data"}, wr_d[idx], rdfun(s));
      chk(rd_s[idx] == c[1:0] && wr_s[idx] == c[3:2], {tag, " R4 size"},
          {rd_s[idx], wr_s[idx]}, {c[1:0], c[3:2]});
      chk(rd_m[idx] == c[8] && wr_m[idx] == c[9], {tag, " R11 master"},
          {rd_m[idx], wr_m[idx]}, {c[8], c[9]});
      s = nstep(s, c[1:0], c[5:4]);
      d = nstep(d, c[3:2], c[7:6]);
      idx++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R1 act=timeout exp=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    bit ok;
    int idx, snap_d, snap_r;
    logic [31:0] c0, c1, c2;

    tick(5);
    rst = 1'b0;
    tick(2);
    // R1: reset state
    chk(!irq && !desc_req && !mem_req, "R1 outputs", {irq, desc_req, mem_req}, 0);
    rreg(3'd0, v); chk(v == 0, "R1 enable", v, 0);
    rreg(3'd1, v); chk(v == 0, "R1 source base", v, 0);
    rreg(3'd2, v); chk(v == 0, "R1 first descriptor", v, 0);
    rreg(3'd3, v); chk(v == 0, "R1 mask", v, 0);
    rreg(3'd4, v); chk(v == 0, "R1 status", v, 0);

    // Chain of three blocks, no block interrupts
    c0 = 32'h0000_0112; c1 = 32'h0000_0261; c2 = 32'h0000_00AA;
    put_desc(32'h100, 32'h2000, c0, 32'h200, 3);
    put_desc(32'h200, 32'h3000, c1, 32'h300, 2);
    put_desc(32'h300, 32'h4000, c2, 32'h0, 4);
    wreg(3'd1, 32'h1000); wreg(3'd2, 32'h100); wreg(3'd3, 32'h2);
    clear_logs();
    wreg(3'd0, 32'h1);
    rreg(3'd0, v); chk(v[0] == 1'b1, "R2 enable reads 1", v, 1);
    tick(20);
    wreg(3'd0, 32'h1);
    wait_idle(ok);
    chk(ok, "R7 chain finishes", ok, 1);
    chk(dr_n == 12, "R2 R3 descriptor reads", dr_n, 12);
    for (int i = 0; i < 12; i++)
      chk(da_log[i] == 32'((i / 4 + 1) * 32'h100 + (i % 4) * 4), "R3 descriptor address",
          da_log[i], 32'((i / 4 + 1) * 32'h100 + (i % 4) * 4));
    chk(rd_n == 9 && wr_n == 9, "R4 unit count", rd_n, 9);
    idx = 0;
    verify_block(idx, 32'h1000, 32'h2000, c0, 3, "blk0");
    verify_block(idx, 32'h1000, 32'h3000, c1, 2, "blk1");
    verify_block(idx, 32'h1000, 32'h4000, c2, 4, "blk2");
    rreg(3'd4, v); chk(v == 2, "R7 status transfer only", v, 2);
    rreg(3'd0, v); chk(v == 0, "R7 enable cleared", v, 0);
    tick(2);
    chk(irq == 1'b1, "R8 irq from transfer status", irq, 1);
    wreg(3'd4, 32'h2);
    tick(2);
    chk(irq == 1'b0, "R8 irq cleared", irq, 0);
    rreg(3'd4, v); chk(v == 0, "R8 status cleared", v, 0);

    // Stall between blocks
    c0 = 32'h0000_2012; c1 = 32'h0000_2000;
    put_desc(32'h500, 32'h6000, c0, 32'h600, 2);
    put_desc(32'h600, 32'h7000, c1, 32'h0, 2);
    wreg(3'd2, 32'h500); wreg(3'd3, 32'h3);
    clear_logs();
    wreg(3'd0, 32'h1);
    ok = 1'b0;
    reg_addr = 3'd4;
    for (int i = 0; i < 500; i++) begin
      tick();
      if (reg_rdata[0]) begin ok = 1'b1; break; end
    end
    chk(ok, "R6 block status raised", ok, 1);
    tick(2);
    snap_d = dr_n; snap_r = rd_n + wr_n;
    tick(30);
    chk(dr_n == snap_d && rd_n + wr_n == snap_r, "R6 stall issues nothing",
        dr_n + rd_n + wr_n, snap_d + snap_r);
    chk(irq == 1'b1, "R8 irq from block status", irq, 1);
    rreg(3'd0, v); chk(v == 1, "R6 enable held during stall", v, 1);
    wreg(3'd4, 32'h1);
    wait_idle(ok);
    chk(ok && dr_n == 8, "R6 resumes after clear", dr_n, 8);
    idx = 0;
    verify_block(idx, 32'h1000, 32'h6000, c0, 2, "stall0");
    verify_block(idx, 32'h1000, 32'h7000, c1, 2, "stall1");
    rreg(3'd4, v); chk(v == 3, "R6 R7 final status", v, 3);
    wreg(3'd4, 32'h3);

    // Interrupt enable set but block mask clear
    wreg(3'd2, 32'h500); wreg(3'd3, 32'h0);
    clear_logs();
    wreg(3'd0, 32'h1);
    wait_idle(ok);
    chk(ok && dr_n == 8, "R6 no stall when masked", dr_n, 8);
    rreg(3'd4, v); chk(v == 2, "R6 block status not set", v, 2);
    tick(2);
    chk(irq == 1'b0, "R8 transfer status masked", irq, 0);
    wreg(3'd4, 32'h3);

    // Zero-size blocks
    put_desc(32'h700, 32'h9000, 32'h0000_0022, 32'h800, 0);
    put_desc(32'h800, 32'hA000, 32'h0000_0022, 32'h0, 2);
    wreg(3'd2, 32'h700);
    clear_logs();
    wreg(3'd0, 32'h1);
    wait_idle(ok);
    chk(ok && rd_n == 2 && wr_n == 2, "R10 empty block then two units", rd_n, 2);
    idx = 0;
    verify_block(idx, 32'h1000, 32'hA000, 32'h0000_0022, 2, "after-empty");
    put_desc(32'h900, 32'hB000, 32'h0000_0022, 32'h0, 0);
    wreg(3'd2, 32'h900);
    clear_logs();
    wreg(3'd0, 32'h1);
    wait_idle(ok);
    chk(ok && rd_n == 0 && wr_n == 0, "R10 single empty block", rd_n + wr_n, 0);
    rreg(3'd4, v); chk(v == 2, "R10 R7 empty block completes", v, 2);
    wreg(3'd4, 32'h3);

    // Abort mid-block
    put_desc(32'hA00, 32'hC000, 32'h0000_0022, 32'h0, 40);
    wreg(3'd2, 32'hA00);
    clear_logs();
    wreg(3'd0, 32'h1);
    tick(25);
    wreg(3'd0, 32'h0);
    chk(!mem_req && !desc_req, "R9 requests dropped", {mem_req, desc_req}, 0);
    snap_r = rd_n + wr_n; snap_d = dr_n;
    tick(20);
    chk(rd_n + wr_n == snap_r && dr_n == snap_d, "R9 no further access",
        rd_n + wr_n + dr_n, snap_r + snap_d);
    chk(rd_n > 0 && rd_n < 40, "R9 abort hit mid-block", rd_n, 20);
    rreg(3'd0, v); chk(v == 0, "R9 enable reads 0", v, 0);
    rreg(3'd4, v); chk(v == 0, "R9 no completion status", v, 0);

    // Sweep widths, address modes and master selects
    for (int sw = 0; sw < 3; sw++)
      for (int dw = 0; dw < 3; dw++)
        for (int sm = 0; sm < 4; sm++)
          for (int dm = 0; dm < 4; dm++) begin
            logic [31:0] cc;
            cc = 32'(sw) | (32'(dw) << 2) | (32'(sm) << 4) | (32'(dm) << 6)
               | (32'((sw + dm) % 2) << 8) | (32'((dw + sm) % 2) << 9) | (32'(sm) << 10);
            put_desc(32'hD00, 32'h8800, cc, 32'h0, 3);
            wreg(3'd2, 32'hD00);
            clear_logs();
            wreg(3'd0, 32'h1);
            wait_idle(ok);
            chk(ok && rd_n == 3 && wr_n == 3, "R4 sweep unit count", rd_n, 3);
            idx = 0;
            verify_block(idx, 32'h1000, 32'h8800, cc, 3, "sweep");
            wreg(3'd4, 32'h3);
          end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule